// File: doc/BRIEF.md
# Floating-Point Reverse-Subtract Special-Value Resolver

This block sits in front of a floating-point reverse-subtract unit that computes SRC − DEST, where DEST is always a register operand and SRC is either a register, a memory value or a value converted from an integer. It looks at the two operands together with a flag that marks an integer-origin source and a two-bit rounding mode. Each operand is sorted into one of six classes: zero, denormal, normal, infinity, quiet NaN or signalling NaN.

Whenever at least one operand is special (NaN, infinity or zero), the block produces the final answer on its own. That answer is a signed zero, an infinity, a copy of one operand (possibly negated), a quieted NaN or the default quiet NaN. It also raises the invalid-operation and denormal-source flags. When both operands are finite and nonzero it asserts a pass-through signal, and the downstream magnitude datapath then performs the real subtraction. Magnitude arithmetic, rounding and integer conversion happen elsewhere.

The operand format is set by an exponent width and a fraction width. The most significant fraction bit is the quiet bit. Inputs are accepted on a valid strobe, and every output is registered once.

Top module: `fp_rsub_special`

## Requirements
- R1: On each cycle, out_valid_o equals in_valid_i from the previous cycle. The data outputs are loaded only when in_valid_i is high and otherwise hold their last value. Reset clears every output to zero.
- R2: If either operand is a NaN (exponent all ones, fraction nonzero), the result is that operand with the quiet bit (fraction MSB) forced to 1. A NaN in DEST takes precedence over one in SRC. invalid_o is set when either operand is a signalling NaN (quiet bit 0).
- R3: If both operands are infinities of the same sign, invalid_o is set and the result is the default quiet NaN: sign 1, exponent all ones, quiet bit 1, all other fraction bits 0.
- R4: If exactly one operand is infinite, or both are infinities of opposite sign, the result is an infinity. When SRC is infinite the result is SRC; otherwise it is DEST with its sign inverted.
- R5: If both operands are zeros of the same effective sign, the result is +0. The exception is rmode_i = 2'b01 (toward minus infinity), where the result is −0. The other encodings are 2'b00 nearest, 2'b10 toward plus infinity and 2'b11 toward zero.
- R6: If both operands are zeros of opposite effective sign, the result is a zero carrying the sign of SRC.
- R7: When src_is_int_i is high, a zero SRC is treated as +0 whatever its sign bit, and SRC never raises denormal_o.
- R8: If SRC is zero and DEST is finite and nonzero, the result is DEST with its sign inverted. If DEST is zero and SRC is finite and nonzero, the result is SRC.
- R9: If both operands are finite and nonzero (denormals included), pass_through_o is 1 and result_o is all zeros. Otherwise pass_through_o is 0.
- R10: denormal_o is 1 exactly when SRC has a zero exponent, a nonzero fraction and src_is_int_i is low, whatever DEST is.
- R11: invalid_o is never set outside the cases in R2 and R3, and in particular never together with pass_through_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid_i | input | 1 | Operands present this cycle |
| src_i | input | EXP_W+FRAC_W+1 | Minuend operand (SRC) |
| dest_i | input | EXP_W+FRAC_W+1 | Subtrahend register operand (DEST) |
| src_is_int_i | input | 1 | SRC came from an integer conversion |
| rmode_i | input | 2 | Rounding mode, encoded as in R5 |
| out_valid_o | output | 1 | Registered results valid |
| result_o | output | EXP_W+FRAC_W+1 | Resolved result; zero when passing through |
| pass_through_o | output | 1 | Finite pair, normal datapath must subtract |
| invalid_o | output | 1 | Invalid-operation flag |
| denormal_o | output | 1 | Denormal-source flag |

## Verification
Every result and flag is due exactly one clock edge after the cycle in which its operands are presented with in_valid_i high. out_valid_o marks that same cycle. The bench drives one operand pair on each falling edge. On the next falling edge it compares the registered outputs against the expected value it computed for the previous pair, and only then drives the next pair. One idle cycle then checks that out_valid_o drops and the data outputs hold.

// File: rtl/fpsr_pkg.sv
package fpsr_pkg;

    typedef enum logic [2:0] {
        CLS_ZERO   = 3'd0,
        CLS_DENORM = 3'd1,
        CLS_NORMAL = 3'd2,
        CLS_INF    = 3'd3,
        CLS_QNAN   = 3'd4,
        CLS_SNAN   = 3'd5
    } fpsr_cls_e;

    typedef enum logic [1:0] {
        RM_NEAREST = 2'b00,
        RM_DOWN    = 2'b01,
        RM_UP      = 2'b10,
        RM_ZERO    = 2'b11
    } fpsr_rmode_e;

    function automatic logic cls_is_nan(input fpsr_cls_e c);
        return (c == CLS_QNAN) || (c == CLS_SNAN);
    endfunction

    function automatic logic cls_is_finite_nz(input fpsr_cls_e c);
        return (c == CLS_DENORM) || (c == CLS_NORMAL);
    endfunction

endpackage

// File: rtl/fpsr_classify.sv
module fpsr_classify
    import fpsr_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int W     = EXP_W + FRAC_W + 1
) (
    input  logic [W-1:0] op_i,
    input  logic         zero_pos_i,
    output fpsr_cls_e    cls_o,
    output logic         sign_o
);

    logic [EXP_W-1:0]  exp_w;
    logic [FRAC_W-1:0] frac_w;

    assign exp_w  = op_i[W-2:FRAC_W];
    assign frac_w = op_i[FRAC_W-1:0];

    always_comb begin
        if (exp_w == '0) begin
            cls_o = (frac_w == '0) ? CLS_ZERO : CLS_DENORM;
        end else if (exp_w == '1) begin
            if (frac_w == '0)
                cls_o = CLS_INF;
            else if (frac_w[FRAC_W-1])
                cls_o = CLS_QNAN;
            else
                cls_o = CLS_SNAN;
        end else begin
            cls_o = CLS_NORMAL;
        end
    end

    assign sign_o = (zero_pos_i && (cls_o == CLS_ZERO)) ? 1'b0 : op_i[W-1];

endmodule

// File: rtl/fpsr_zero_sign.sv
module fpsr_zero_sign
    import fpsr_pkg::*;
(
    input  logic        src_sign_i,
    input  logic        dest_sign_i,
    input  logic [1:0]  rmode_i,
    output logic        sign_o
);

    always_comb begin
        if (src_sign_i != dest_sign_i)
            sign_o = src_sign_i;
        else
            sign_o = (rmode_i == RM_DOWN);
    end

endmodule

// File: rtl/fpsr_resolve.sv
module fpsr_resolve
    import fpsr_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int W     = EXP_W + FRAC_W + 1
) (
    input  logic [W-1:0] src_i,
    input  logic [W-1:0] dest_i,
    input  fpsr_cls_e    src_cls_i,
    input  fpsr_cls_e    dest_cls_i,
    input  logic         src_sign_i,
    input  logic         dest_sign_i,
    input  logic         zero_sign_i,
    output logic [W-1:0] result_o,
    output logic         pass_o,
    output logic         invalid_o
);

    localparam logic [W-1:0] QUIET_MASK =
        {{(EXP_W + 1){1'b0}}, 1'b1, {(FRAC_W - 1){1'b0}}};
    localparam logic [W-1:0] DEFAULT_QNAN =
        {1'b1, {EXP_W{1'b1}}, 1'b1, {(FRAC_W - 1){1'b0}}};

    logic [W-1:0] dest_neg;
    logic         any_snan;

    assign dest_neg = {~dest_i[W-1], dest_i[W-2:0]};
    assign any_snan = (src_cls_i == CLS_SNAN) || (dest_cls_i == CLS_SNAN);

    always_comb begin
        result_o  = '0;
        pass_o    = 1'b0;
        invalid_o = 1'b0;
        if (cls_is_nan(src_cls_i) || cls_is_nan(dest_cls_i)) begin
            result_o  = cls_is_nan(dest_cls_i) ? (dest_i | QUIET_MASK)
                                               : (src_i | QUIET_MASK);
            invalid_o = any_snan;
        end else if (src_cls_i == CLS_INF && dest_cls_i == CLS_INF) begin
            if (src_sign_i == dest_sign_i) begin
                result_o  = DEFAULT_QNAN;
                invalid_o = 1'b1;
            end else begin
                result_o  = src_i;
            end
        end else if (src_cls_i == CLS_INF) begin
            result_o = src_i;
        end else if (dest_cls_i == CLS_INF) begin
            result_o = dest_neg;
        end else if (src_cls_i == CLS_ZERO && dest_cls_i == CLS_ZERO) begin
            result_o = {zero_sign_i, {(W - 1){1'b0}}};
        end else if (src_cls_i == CLS_ZERO) begin
            result_o = dest_neg;
        end else if (dest_cls_i == CLS_ZERO) begin
            result_o = src_i;
        end else begin
            pass_o = 1'b1;
        end
    end

endmodule

// File: rtl/fp_rsub_special.sv
module fp_rsub_special
    import fpsr_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int W     = EXP_W + FRAC_W + 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid_i,
    input  logic [W-1:0] src_i,
    input  logic [W-1:0] dest_i,
    input  logic         src_is_int_i,
    input  logic [1:0]   rmode_i,
    output logic         out_valid_o,
    output logic [W-1:0] result_o,
    output logic         pass_through_o,
    output logic         invalid_o,
    output logic         denormal_o
);

    localparam int NUM_OPS = 2;

    typedef struct packed {
        logic         valid;
        logic [W-1:0] result;
        logic         pass;
        logic         invalid;
        logic         denormal;
    } state_t;

    state_t state_d, state_q;

    logic [W-1:0] ops       [NUM_OPS];
    logic         zero_pos  [NUM_OPS];
    fpsr_cls_e    cls       [NUM_OPS];
    logic         sign_eff  [NUM_OPS];

    assign ops[0]      = src_i;
    assign ops[1]      = dest_i;
    assign zero_pos[0] = src_is_int_i;
    assign zero_pos[1] = 1'b0;

    for (genvar g = 0; g < NUM_OPS; g++) begin : g_cls
        fpsr_classify #(
            .EXP_W  (EXP_W),
            .FRAC_W (FRAC_W)
        ) i_classify (
            .op_i       (ops[g]),
            .zero_pos_i (zero_pos[g]),
            .cls_o      (cls[g]),
            .sign_o     (sign_eff[g])
        );
    end

    logic         zero_sign;
    logic [W-1:0] res_w;
    logic         pass_w;
    logic         inv_w;

    fpsr_zero_sign i_zero_sign (
        .src_sign_i  (sign_eff[0]),
        .dest_sign_i (sign_eff[1]),
        .rmode_i     (rmode_i),
        .sign_o      (zero_sign)
    );

    fpsr_resolve #(
        .EXP_W  (EXP_W),
        .FRAC_W (FRAC_W)
    ) i_resolve (
        .src_i       (src_i),
        .dest_i      (dest_i),
        .src_cls_i   (cls[0]),
        .dest_cls_i  (cls[1]),
        .src_sign_i  (sign_eff[0]),
        .dest_sign_i (sign_eff[1]),
        .zero_sign_i (zero_sign),
        .result_o    (res_w),
        .pass_o      (pass_w),
        .invalid_o   (inv_w)
    );

    always_comb begin
        state_d       = state_q;
        state_d.valid = in_valid_i;
        if (in_valid_i) begin
            state_d.result   = res_w;
            state_d.pass     = pass_w;
            state_d.invalid  = inv_w;
            state_d.denormal = (cls[0] == CLS_DENORM) && !src_is_int_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= '0;
        else
            state_q <= state_d;
    end

    assign out_valid_o    = state_q.valid;
    assign result_o       = state_q.result;
    assign pass_through_o = state_q.pass;
    assign invalid_o      = state_q.invalid;
    assign denormal_o     = state_q.denormal;

endmodule

// File: rtl/fpsr_checker.sv
module fpsr_checker #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int W     = EXP_W + FRAC_W + 1
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid_i,
    input logic [W-1:0] src_i,
    input logic [W-1:0] dest_i,
    input logic         src_is_int_i,
    input logic [1:0]   rmode_i,
    input logic         out_valid_o,
    input logic [W-1:0] result_o,
    input logic         pass_through_o,
    input logic         invalid_o,
    input logic         denormal_o
);

    localparam logic [W-1:0] DQNAN = {1'b1, {EXP_W{1'b1}}, 1'b1, {(FRAC_W - 1){1'b0}}};

    function automatic logic is_nan(input logic [W-1:0] v);
        return (v[W-2:FRAC_W] == '1) && (v[FRAC_W-1:0] != '0);
    endfunction
    function automatic logic is_inf(input logic [W-1:0] v);
        return (v[W-2:FRAC_W] == '1) && (v[FRAC_W-1:0] == '0);
    endfunction
    function automatic logic is_zero(input logic [W-1:0] v);
        return v[W-2:0] == '0;
    endfunction
    function automatic logic is_fin_nz(input logic [W-1:0] v);
        return (v[W-2:FRAC_W] != '1) && !is_zero(v);
    endfunction

    assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o == $past(in_valid_i));

    assert_nan_out_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid_i && (is_nan(src_i) || is_nan(dest_i)) |=> is_nan(result_o));

    assert_like_inf_R3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid_i && is_inf(src_i) && is_inf(dest_i) && (src_i[W-1] == dest_i[W-1])
        |=> invalid_o && (result_o == DQNAN));

    assert_zero_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid_i && !src_is_int_i && is_zero(src_i) && is_zero(dest_i)
        && (src_i[W-1] == dest_i[W-1]) && (rmode_i == 2'b01)
        |=> result_o == {1'b1, {(W - 1){1'b0}}});

    assert_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid_i && is_fin_nz(src_i) && is_fin_nz(dest_i)
        |=> pass_through_o && !invalid_o);

    assert_denorm_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid_i && !src_is_int_i && (src_i[W-2:FRAC_W] == '0) && (src_i[FRAC_W-1:0] != '0)
        |=> denormal_o);

    assert_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        pass_through_o |-> !invalid_o);

endmodule

bind fp_rsub_special fpsr_checker #(
    .EXP_W  (EXP_W),
    .FRAC_W (FRAC_W)
) i_fpsr_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .in_valid_i     (in_valid_i),
    .src_i          (src_i),
    .dest_i         (dest_i),
    .src_is_int_i   (src_is_int_i),
    .rmode_i        (rmode_i),
    .out_valid_o    (out_valid_o),
    .result_o       (result_o),
    .pass_through_o (pass_through_o),
    .invalid_o      (invalid_o),
    .denormal_o     (denormal_o)
);

// File: tb/test_fp_rsub_special.sv
`timescale 1ns/1ps
module test_fp_rsub_special;

    localparam int EW = 3;
    localparam int FW = 2;
    localparam int W  = EW + FW + 1;
    localparam int N  = 1 << W;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [W-1:0] src = '0;
    logic [W-1:0] dest = '0;
    logic         is_int = 1'b0;
    logic [1:0]   rmode = 2'b00;
    logic         out_valid;
    logic [W-1:0] result;
    logic         pass_t;
    logic         inv;
    logic         den;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    fp_rsub_special #(.EXP_W(EW), .FRAC_W(FW)) i_fp_rsub_special (
        .clk            (clk),
        .rst_n          (rst_n),
        .in_valid_i     (in_valid),
        .src_i          (src),
        .dest_i         (dest),
        .src_is_int_i   (is_int),
        .rmode_i        (rmode),
        .out_valid_o    (out_valid),
        .result_o       (result),
        .pass_through_o (pass_t),
        .invalid_o      (inv),
        .denormal_o     (den)
    );

    // expected = {result, pass, invalid, denormal}
    logic [W+2:0] exp_q;
    string        tag_q;

    task automatic model(input int s, input int d, input int it, input int rm,
                         output logic [W+2:0] e, output string tag);
        int s_exp  = (s >> FW) % (1 << EW);
        int s_frac = s % (1 << FW);
        int s_sgn  = s >> (W - 1);
        int d_exp  = (d >> FW) % (1 << EW);
        int d_frac = d % (1 << FW);
        int d_sgn  = d >> (W - 1);
        int emax   = (1 << EW) - 1;
        int qbit   = 1 << (FW - 1);
        bit s_nan  = (s_exp == emax) && (s_frac != 0);
        bit d_nan  = (d_exp == emax) && (d_frac != 0);
        bit s_inf  = (s_exp == emax) && (s_frac == 0);
        bit d_inf  = (d_exp == emax) && (d_frac == 0);
        bit s_zero = (s_exp == 0) && (s_frac == 0);
        bit d_zero = (d_exp == 0) && (d_frac == 0);
        int r = 0;
        bit p = 0, iv = 0, dn;
        dn = (s_exp == 0) && (s_frac != 0) && (it == 0);
        if (s_zero && it != 0) s_sgn = 0;
        tag = "R9";
        if (s_nan || d_nan) begin
            r   = d_nan ? (d | qbit) : (s | qbit);
            iv  = (s_nan && (s_frac & qbit) == 0) || (d_nan && (d_frac & qbit) == 0);
            tag = "R2";
        end else if (s_inf && d_inf && s_sgn == d_sgn) begin
            r = (N / 2) + (emax << FW) + qbit; iv = 1; tag = "R3";
        end else if (s_inf) begin
            r = s; tag = "R4";
        end else if (d_inf) begin
            r = d ^ (N / 2); tag = "R4";
        end else if (s_zero && d_zero) begin
            if (s_sgn != d_sgn) begin
                r = s_sgn * (N / 2); tag = "R6";
            end else begin
                r = (rm == 1) ? N / 2 : 0; tag = "R5";
            end
            if (it != 0) tag = "R7";
        end else if (s_zero) begin
            r = d ^ (N / 2); tag = "R8";
        end else if (d_zero) begin
            r = s; tag = "R8";
        end else begin
            p = 1;
        end
        if (dn && tag == "R9") tag = "R10";
        e = {r[W-1:0], p, iv, dn};
    endtask

    task automatic check(input string tag, input logic [W+2:0] act, input logic [W+2:0] e);
        total++;
        if (act !== e) begin
            bad++;
            $display("FAIL %s act res=%h pass=%b inv=%b den=%b exp res=%h pass=%b inv=%b den=%b",
                     tag, act[W+2:3], act[2], act[1], act[0], e[W+2:3], e[2], e[1], e[0]);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic         pend = 1'b0;
        logic [W-1:0] held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1", {out_valid, result, pass_t, inv, den}, '0);
        for (int rm = 0; rm < 4; rm++) begin
            for (int it = 0; it < 2; it++) begin
                for (int s = 0; s < N; s++) begin
                    for (int d = 0; d < N; d++) begin
                        logic [W+2:0] e;
                        string        t;
                        @(negedge clk);
                        if (pend) begin
                            check("R1", {3'b0, out_valid}, 4'd1);
                            check(tag_q, {result, pass_t, inv, den}, exp_q);
                        end
                        in_valid = 1'b1;
                        src      = W'(s);
                        dest     = W'(d);
                        is_int   = it[0];
                        rmode    = rm[1:0];
                        model(s, d, it, rm, e, t);
                        exp_q = e;
                        tag_q = t;
                        pend  = 1'b1;
                    end
                end
            end
        end
        @(negedge clk);
        check(tag_q, {result, pass_t, inv, den}, exp_q);
        held     = result;
        // R1: idle cycle with changed operands must not load
        in_valid = 1'b0;
        src      = '0;
        dest     = '0;
        @(negedge clk);
        check("R1", {out_valid, result}, {1'b0, held});
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule